// File: doc/BRIEF.md
# Byte-Lane Synchronous Memory with Registered Read Path

This block is the storage array and data path of a synchronous static memory. All of its inputs are taken on the rising clock edge. The address and the select flag come already registered from an address sequencer elsewhere. Write data is 36 bits wide and is split into four 9-bit lanes. Each lane has its own enable. A global-write input overrides the lane enables and stores the whole word.

A write needs no separate strobe. It completes at the clock edge that samples it. A read goes through two registers. At the sampling edge the array word is captured into a read stage. At the next edge it moves into the output register, which drives the data pins. An active-low output enable gates the pin drivers with no clock involved. The depth is a parameter: `ADDR_W=15` gives the full 32768-word array, and the default is smaller.

No handshake is used. The data pins do not apply back-pressure: any selected read reaches the output register on the second edge after it is sampled. The output register is overwritten only by a read, so each value stays on the pins until the next read replaces it.

Top module: `sram_bytewr_dp`

## Requirements
- R1: When `cs` and `gw_en` are both high at an edge, all four lanes of the word at `addr` take `wdata`, whatever `wr_en` and `lane_wr` are.
- R2: When `cs` and `wr_en` are high, `gw_en` is low and `lane_wr` is not zero, only the lanes whose `lane_wr` bit is 1 are written. The other lanes keep their contents.
- R3: When `wr_en` is high with all four `lane_wr` bits set, the whole word is written.
- R4: Lane positions are fixed: `lane_wr[0]` controls bits 8:0, `lane_wr[1]` bits 17:9, `lane_wr[2]` bits 26:18 and `lane_wr[3]` bits 35:27.
- R5: A read sampled at edge N does not change `dq_out` at edge N. The word read appears on `dq_out` after edge N+1.
- R6: When `cs` is low at edge N, nothing is written and the output register keeps its value across edge N+1.
- R7: A write cycle leaves the output register unchanged across the following edge. A selected cycle with `gw_en` low and either `wr_en` low or `lane_wr` zero is a read.
- R8: `oe_n` acts without a clock. While it is low, `dq_drv` is 1 and `dq_out` carries the output register. While it is high, `dq_drv` is 0 and `dq_out` is high-impedance.
- R9: Synchronous reset (`rst_n` low at an edge) clears the output register and the read stage to zero. The array contents are not reset.
- R10: A read in the cycle after a write to the same address returns the new word. A write in the cycle after a read does not alter the word that read delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| cs | input | 1 | Registered select flag from the sequencer |
| addr | input | ADDR_W | Registered word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| lane_wr | input | 4 | Per-lane write enables |
| wr_en | input | 1 | Lane-qualified write enable |
| gw_en | input | 1 | Global write: all lanes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 36 | Data pins; high-impedance when disabled |
| dq_drv | output | 1 | High while the pin drivers are on |

## Verification
Two operations can be in flight in the same cycle: a write to an address, and the output register moving forward the word that an earlier read of the same address captured. The bench provokes this by reading an address and writing new data to it on the very next edge. It then checks that the pins show the old word, and that a later read returns the new one. It also issues a write followed at once by a read of that address, and changes `oe_n` between clock edges while a read is still in the pipeline. Every result is compared against a word merge that the bench computes arithmetically.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Expand a per-lane mask into a per-bit mask of a fixed maximum width.
  function automatic logic [63:0] lane_bits(input logic [7:0] lanes, input int lane_w, input int n_lanes);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < n_lanes; i++)
      for (int b = 0; b < lane_w; b++)
        if (lanes[i]) m[i*lane_w + b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/wr_decode.sv
module wr_decode
  import sram_dp_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 cs,
  input  logic                 gw_en,
  input  logic                 wr_en,
  input  logic [NUM_LANES-1:0] lane_wr,
  output logic [NUM_LANES-1:0] lane_we,
  output cyc_kind_e            kind
);

  logic [NUM_LANES-1:0] sel_lanes;

  always_comb begin
    if (gw_en)      sel_lanes = '1;
    else if (wr_en) sel_lanes = lane_wr;
    else            sel_lanes = '0;
  end

  always_comb begin
    if (!cs)             kind = CYC_IDLE;
    else if (|sel_lanes) kind = CYC_WRITE;
    else                 kind = CYC_READ;
  end

  assign lane_we = (kind == CYC_WRITE) ? sel_lanes : '0;

endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= cells[addr];
  end

  assign rd = rd_q;

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drv
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  assign dq_drv = !oe_n;
  assign dq_out = dq_drv ? q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_bytewr_dp.sv
module sram_bytewr_dp
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANE_W    = 9,
  parameter int NUM_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANE_W*NUM_LANES-1:0] wdata,
  input  logic [NUM_LANES-1:0]        lane_wr,
  input  logic                        wr_en,
  input  logic                        gw_en,
  input  logic                        oe_n,
  output logic [LANE_W*NUM_LANES-1:0] dq_out,
  output logic                        dq_drv
);

  localparam int DATA_W = LANE_W * NUM_LANES;

  cyc_kind_e            kind;
  logic [NUM_LANES-1:0] lane_we;
  logic                 rd_req;
  logic                 stage_v;
  logic [DATA_W-1:0]    stage_d;
  logic [DATA_W-1:0]    out_q;

  wr_decode #(.NUM_LANES(NUM_LANES)) u_dec (
    .cs(cs), .gw_en(gw_en), .wr_en(wr_en), .lane_wr(lane_wr),
    .lane_we(lane_we), .kind(kind)
  );

  assign rd_req = (kind == CYC_READ);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk), .we(lane_we[g]), .re(rd_req), .addr(addr),
      .wd(wdata[g*LANE_W +: LANE_W]),
      .rd(stage_d[g*LANE_W +: LANE_W])
    );
  end

  // Read stage valid flag: marks that stage_d holds a word for the output register.
  always_ff @(posedge clk) begin
    if (!rst_n) stage_v <= 1'b0;
    else        stage_v <= rd_req;
  end

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ld(stage_v), .d(stage_d), .oe_n(oe_n),
    .q(out_q), .dq_out(dq_out), .dq_drv(dq_drv)
  );

endmodule

// File: rtl/sram_bytewr_dp_chk.sv
module sram_bytewr_dp_chk #(
  parameter int ADDR_W    = 8,
  parameter int LANE_W    = 9,
  parameter int NUM_LANES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cs,
  input logic [ADDR_W-1:0]           addr,
  input logic [LANE_W*NUM_LANES-1:0] wdata,
  input logic [NUM_LANES-1:0]        lane_wr,
  input logic                        wr_en,
  input logic                        gw_en,
  input logic                        oe_n,
  input logic                        dq_drv,
  input logic [LANE_W*NUM_LANES-1:0] out_q
);

  logic is_wr, is_rd;
  assign is_wr = cs && (gw_en || (wr_en && (|lane_wr)));
  assign is_rd = cs && !is_wr;

  // R1
  gw_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && gw_en) ##1 (is_rd && addr == $past(addr)) |=> ##1 (out_q == $past(wdata, 3)));

  // R2
  lane_a_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !gw_en && wr_en && lane_wr == 1) ##1 (is_rd && addr == $past(addr))
    |=> ##1 (out_q[LANE_W-1:0] == $past(wdata[LANE_W-1:0], 3)));

  // R6
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ##1 $stable(out_q));

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> ##1 $stable(out_q));

  // R8
  always_comb begin
    oe_drive_chk: assert (dq_drv == !oe_n);
  end

endmodule

bind sram_bytewr_dp sram_bytewr_dp_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .NUM_LANES(NUM_LANES)
) u_chk (.*);

// File: tb/sram_bytewr_dp_test.sv
module sram_bytewr_dp_test;

  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n, cs, wr_en, gw_en, oe_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata;
  logic [3:0]  lane_wr;
  logic [35:0] dq_out;
  logic        dq_drv;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [35:0] mem [NW];
  logic [35:0] exp_out, st_d;
  logic        st_v;

  always #4 clk = ~clk;

  sram_bytewr_dp #(.ADDR_W(AW), .LANE_W(9), .NUM_LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wdata(wdata),
    .lane_wr(lane_wr), .wr_en(wr_en), .gw_en(gw_en), .oe_n(oe_n),
    .dq_out(dq_out), .dq_drv(dq_drv)
  );

  function automatic logic [35:0] pat(input int a, input int s);
    return 36'(64'h9_A5C3_1E77 ^ (64'(a) * 64'h0_0713_5B29) ^ (64'(s) * 64'h2_4F19_8D03));
  endfunction

  function automatic logic [35:0] expand(input logic [3:0] l);
    logic [35:0] m = '0;
    for (int i = 0; i < 4; i++) if (l[i]) m[i*9 +: 9] = 9'h1FF;
    return m;
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] expv);
    tests++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic tick(input logic c, input logic g, input logic w, input logic [3:0] l,
                      input int a, input logic [35:0] d, input string tag);
    logic wrc, rd;
    logic [35:0] m;
    cs = c; gw_en = g; wr_en = w; lane_wr = l; addr = a[AW-1:0]; wdata = d;
    @(posedge clk);
    wrc = c && (g || (w && l != 4'h0));
    rd  = c && !wrc;
    if (st_v) exp_out = st_d;
    st_v = rd;
    if (rd) st_d = mem[a];
    if (wrc) begin
      m = g ? '1 : expand(l);
      mem[a] = (mem[a] & ~m) | (d & m);
    end
    #2;
    check(tag, dq_out, exp_out);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs = 0; wr_en = 0; gw_en = 0; oe_n = 0;
    addr = '0; wdata = '0; lane_wr = '0;
    exp_out = '0; st_v = 0; st_d = '0;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 reset output", dq_out, 36'h0);
    check("R8 drive on", {35'h0, dq_drv}, 36'h1);
    rst_n = 1'b1;

    // R1: fill every word with global write, lane inputs set to junk
    for (int a = 0; a < NW; a++) tick(1, 1, a[0], 4'(a), a, pat(a, 0), "R1 fill");
    // R5/R1: back-to-back reads of all words
    for (int a = 0; a < NW; a++) tick(1, 0, 0, 4'(a), a, '0, "R1/R5 read sweep");
    tick(0, 0, 0, 0, 0, '0, "R5 drain");
    tick(0, 0, 0, 0, 0, '0, "R6 idle hold");

    // R2/R3/R4/R7: every lane mask, lane mask 0 counts as a read
    for (int k = 0; k < 16; k++) begin
      tick(1, 0, 1, 4'(k), k, pat(k, 7), (k == 15) ? "R3 full lane write" : "R2/R7 lane write");
      tick(0, 0, 0, 0, 0, '0, "R7 write hold");
      tick(1, 0, 0, 0, k, '0, "R4 readback issue");
      tick(0, 0, 0, 0, 0, '0, "R4 lane merge");
      tick(0, 0, 0, 0, 0, '0, "R6 hold");
    end

    // R1: global write overrides a partial lane mask
    tick(1, 1, 1, 4'b0001, 3, pat(3, 9), "R1 override");
    tick(1, 0, 0, 0, 3, '0, "R10 write then read");
    tick(0, 0, 0, 0, 0, '0, "R1 override data");

    // R6: deselected write attempt must not store
    tick(0, 1, 1, 4'hF, 5, pat(5, 11), "R6 deselect write");
    tick(1, 0, 0, 0, 5, '0, "R6 readback issue");
    tick(0, 0, 0, 0, 0, '0, "R6 no store");

    // R10: read followed at once by a write to the same address
    tick(1, 0, 0, 0, 6, '0, "R10 read");
    tick(1, 1, 0, 0, 6, pat(6, 13), "R10 collide write");
    tick(0, 0, 0, 0, 0, '0, "R10 old word kept");
    tick(1, 0, 0, 0, 6, '0, "R10 reread");
    tick(0, 0, 0, 0, 0, '0, "R10 new word");

    // R8: enable toggles between edges with a read in flight
    tick(1, 0, 0, 0, 2, '0, "R5 stage");
    oe_n = 1'b1; #1;
    check("R8 drive off", {35'h0, dq_drv}, 36'h0);
    oe_n = 1'b0; #1;
    check("R8 drive back", {35'h0, dq_drv}, 36'h1);
    check("R8 value while staged", dq_out, exp_out);
    tick(0, 0, 0, 0, 0, '0, "R8 R5 delivered");

    // R9: reset mid-stream clears output register
    rst_n = 1'b0;
    @(posedge clk); #2;
    exp_out = '0; st_v = 0;
    check("R9 reset clears", dq_out, 36'h0);
    rst_n = 1'b1;
    tick(1, 0, 0, 0, 6, '0, "R9 memory kept issue");
    tick(0, 0, 0, 0, 0, '0, "R9 memory kept");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule